// File: doc/BRIEF.md
# Disk Controller Register Interface

This block sits between a 12-bit minicomputer I/O bus and the command sequencer of a controller serving four cartridge drives. Each bus transfer arrives as a one-cycle strobe with a 3-bit operation code and a 12-bit accumulator word. The block decodes the operation and holds the controller's state: a status word, a command word, a disk address, a memory address, a busy flag and an interrupt request. It answers each strobe one cycle later with a returned accumulator word and a skip flag.

Two operations ask for drive work: loading the disk address, and the drive-reset form of the clear operation. For these the block raises a one-cycle launch strobe that carries the function code, the drive number and the target cylinder. A separate execution block carries out the work. It reports back through a single-cycle event that ORs status bits in and writes the busy flag. Drive presence and drive motion arrive as plain per-drive inputs.

While the busy flag is set, every operation that would load a register is refused. The refused load leaves the register unchanged and sets the busy-error status bit instead.

Top module: `dkc_regif`

## Requirements
- R1: A synchronous active-high reset clears the status, command, disk-address and memory-address words, the busy flag, the interrupt request and every response and launch output.
- R2: Code 1 (test) returns the accumulator unchanged and asserts skip exactly when the status held before the strobe has done (octal 04000) or any error bit (octal 00177) set.
- R3: Code 6 (load command) copies the accumulator into the command word and zeroes status when idle. When busy, it leaves the command word unchanged and sets busy-error (octal 00100).
- R4: Code 4 (load memory address) copies the accumulator into the memory-address word when idle. When busy, it sets busy-error and leaves the word unchanged.
- R5: Code 3 (load address and launch), when idle, stores the accumulator as the disk address and raises the launch strobe. The strobe carries function = command bits 11:9, drive = command bits 2:1, and cylinder = {command bit 0, accumulator bits 11:5}. When busy, it sets busy-error, leaves the address unchanged and raises no launch.
- R6: Code 2 (clear) always zeroes status first; the accumulator's two low bits pick the sub-operation. Sub-code 0 then sets busy-error if busy. Sub-code 3 does nothing further, even when busy.
- R7: Clear sub-code 1 zeroes the command, disk-address and memory-address words and the busy flag, and pulses cancel_all for one cycle.
- R8: Clear sub-code 2, when idle, raises a launch with function 3 (seek), cylinder 0 and the selected drive. When busy, it sets busy-error and raises no launch.
- R9: Code 5 (read status) sets status bit 02000 to the selected drive's active input and bit 00200 to the inverse of its ready input, the drive being command bits 2:1. It returns the refreshed status word.
- R10: After every strobe except code 5, and after every execution event, the interrupt request equals command bit 00400 AND (status AND octal 04177 is nonzero). Code 5 leaves it unchanged.
- R11: Codes 0 and 7 change no register.
- R12: An execution event ORs its status bits into the status word and writes its busy value into the busy flag.
- R13: Every strobe gives rsp_valid exactly one cycle later. Codes other than 1 and 5 return zero. A launch strobe lasts one cycle and coincides with that response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_valid | input | 1 | Bus operation strobe |
| pulse_code | input | 3 | Operation code |
| acc_in | input | 12 | Accumulator word from the bus |
| drv_ready | input | 4 | Per-drive present and ready |
| drv_active | input | 4 | Per-drive heads in motion |
| ex_valid | input | 1 | Execution-block event |
| ex_stat_set | input | 12 | Status bits to OR in on an event |
| ex_busy | input | 1 | New busy value on an event |
| rsp_valid | output | 1 | Response to the previous strobe |
| acc_out | output | 12 | Returned accumulator word |
| skip | output | 1 | Skip request for the test operation |
| go_valid | output | 1 | Launch strobe to the execution block |
| go_func | output | 3 | Launch function code |
| go_drive | output | 2 | Launch drive number |
| go_cyl | output | 8 | Launch cylinder |
| cancel_all | output | 1 | Cancel all drive activity |
| stat_o | output | 12 | Status word |
| cmd_o | output | 12 | Command word |
| dskaddr_o | output | 12 | Disk-address word |
| memaddr_o | output | 12 | Memory-address word |
| busy_o | output | 1 | Controller busy flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that a bus strobe and an execution event never arrive in the same cycle. If they did, the event would be dropped, so a checker flags any overlap. The stimulus drives the two from a single sequencer and lets only one of them fire per cycle, both in the directed steps and in the random phase. The drive inputs are taken as quasi-static. The bench changes them only between strobes, so the status refresh always sees a settled value.

// File: rtl/dkc_pkg.sv
package dkc_pkg;

    localparam int WORD_W = 12;
    localparam int FUNC_W = 3;
    localparam int SEL_W  = 2;
    localparam int CYL_W  = 8;

    // status bit positions
    localparam int ST_DONE  = 11;
    localparam int ST_HMOV  = 10;
    localparam int ST_NRDY  = 7;
    localparam int ST_BUSYE = 6;

    // command field positions
    localparam int CM_FUNC_LO = 9;
    localparam int CM_IE      = 8;
    localparam int CM_SEL_LO  = 1;
    localparam int CM_CYHI    = 0;

    localparam logic [WORD_W-1:0] ERR_MASK  = 12'o0177;
    localparam logic [WORD_W-1:0] ATTN_MASK = 12'o4177;
    localparam logic [FUNC_W-1:0] FN_SEEK   = 3'd3;

    typedef enum logic [2:0] {
        OP_RSVD0   = 3'd0,
        OP_TEST    = 3'd1,
        OP_CLEAR   = 3'd2,
        OP_LDGO    = 3'd3,
        OP_LDMA    = 3'd4,
        OP_RDSTAT  = 3'd5,
        OP_LDCMD   = 3'd6,
        OP_NOP7    = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        CLR_STATUS = 2'd0,
        CLR_CTRL   = 2'd1,
        CLR_DRIVE  = 2'd2,
        CLR_ONLY   = 2'd3
    } clr_e;

    typedef enum logic [1:0] {
        RET_ZERO = 2'd0,
        RET_PASS = 2'd1,
        RET_STAT = 2'd2
    } ret_e;

    typedef struct packed {
        logic zero_stat;
        logic set_busyerr;
        logic load_cmd;
        logic load_da;
        logic load_ma;
        logic clr_ctrl;
        logic launch;
        logic launch_seek0;
        logic refresh;
        logic reeval_irq;
        logic test_skip;
        ret_e ret;
    } act_t;

    function automatic logic attention(input logic [WORD_W-1:0] st);
        return |(st & ATTN_MASK);
    endfunction

    function automatic logic [CYL_W-1:0] cyl_of(input logic cyhi,
                                                 input logic [WORD_W-1:0] da);
        return {cyhi, da[WORD_W-1:WORD_W-CYL_W+1]};
    endfunction

endpackage

// File: rtl/dkc_decode.sv
module dkc_decode
    import dkc_pkg::*;
(
    input  logic [2:0] op,
    input  logic [1:0] clr_code,
    input  logic       busy,
    output act_t       act
);
    always_comb begin
        act = '0;
        act.ret = RET_ZERO;
        act.reeval_irq = 1'b1;
        unique case (op_e'(op))
            OP_TEST: begin
                act.ret = RET_PASS;
                act.test_skip = 1'b1;
            end
            OP_CLEAR: begin
                act.zero_stat = 1'b1;
                unique case (clr_e'(clr_code))
                    CLR_STATUS: act.set_busyerr = busy;
                    CLR_CTRL:   act.clr_ctrl = 1'b1;
                    CLR_DRIVE: begin
                        act.set_busyerr  = busy;
                        act.launch_seek0 = !busy;
                    end
                    default: ;
                endcase
            end
            OP_LDGO: begin
                act.set_busyerr = busy;
                act.load_da     = !busy;
                act.launch      = !busy;
            end
            OP_LDMA: begin
                act.set_busyerr = busy;
                act.load_ma     = !busy;
            end
            OP_RDSTAT: begin
                act.refresh    = 1'b1;
                act.reeval_irq = 1'b0;
                act.ret        = RET_STAT;
            end
            OP_LDCMD: begin
                act.set_busyerr = busy;
                act.load_cmd    = !busy;
                act.zero_stat   = !busy;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dkc_regfile.sv
module dkc_regfile
    import dkc_pkg::*;
#(
    parameter int N_DRV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pulse_valid,
    input  act_t              act,
    input  logic [WORD_W-1:0] acc_in,
    input  logic [N_DRV-1:0]  drv_ready,
    input  logic [N_DRV-1:0]  drv_active,
    input  logic              ex_valid,
    input  logic [WORD_W-1:0] ex_stat_set,
    input  logic              ex_busy,
    output logic [WORD_W-1:0] stat_q,
    output logic [WORD_W-1:0] stat_next,
    output logic [WORD_W-1:0] cmd_q,
    output logic [WORD_W-1:0] da_q,
    output logic [WORD_W-1:0] ma_q,
    output logic              busy_q,
    output logic              irq_q
);
    logic [WORD_W-1:0] cmd_n, da_n, ma_n;
    logic              busy_n, irq_n;
    logic [SEL_W-1:0]  sel;

    assign sel = cmd_q[CM_SEL_LO +: SEL_W];

    always_comb begin
        stat_next = stat_q;
        cmd_n     = cmd_q;
        da_n      = da_q;
        ma_n      = ma_q;
        busy_n    = busy_q;
        irq_n     = irq_q;
        if (pulse_valid) begin
            if (act.zero_stat)   stat_next = '0;
            if (act.set_busyerr) stat_next[ST_BUSYE] = 1'b1;
            if (act.load_cmd)    cmd_n = acc_in;
            if (act.load_da)     da_n  = acc_in;
            if (act.load_ma)     ma_n  = acc_in;
            if (act.clr_ctrl) begin
                cmd_n  = '0;
                da_n   = '0;
                ma_n   = '0;
                busy_n = 1'b0;
            end
            if (act.refresh) begin
                stat_next[ST_HMOV] = drv_active[sel];
                stat_next[ST_NRDY] = !drv_ready[sel];
            end
            if (act.reeval_irq)
                irq_n = cmd_n[CM_IE] && attention(stat_next);
        end else if (ex_valid) begin
            stat_next = stat_q | ex_stat_set;
            busy_n    = ex_busy;
            irq_n     = cmd_q[CM_IE] && attention(stat_next);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            cmd_q  <= '0;
            da_q   <= '0;
            ma_q   <= '0;
            busy_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            stat_q <= stat_next;
            cmd_q  <= cmd_n;
            da_q   <= da_n;
            ma_q   <= ma_n;
            busy_q <= busy_n;
            irq_q  <= irq_n;
        end
    end

    a_r3_refused_cmd_kept: assert property (@(posedge clk) disable iff (rst)
        (pulse_valid && act.set_busyerr && !act.zero_stat) |=> (stat_q[ST_BUSYE] && $stable(cmd_q)));

    a_r9_refresh_follows_drive: assert property (@(posedge clk) disable iff (rst)
        (pulse_valid && act.refresh) |=>
            (stat_q[ST_HMOV] == $past(drv_active[sel]) && stat_q[ST_NRDY] == !$past(drv_ready[sel])));

    a_r10_irq_tracks_state: assert property (@(posedge clk) disable iff (rst)
        ((pulse_valid && act.reeval_irq) || (!pulse_valid && ex_valid)) |=>
            (irq_q == (cmd_q[CM_IE] && |(stat_q & ATTN_MASK))));

    a_r10_irq_held_on_read: assert property (@(posedge clk) disable iff (rst)
        (pulse_valid && act.refresh) |=> $stable(irq_q));
endmodule

// File: rtl/dkc_respond.sv
module dkc_respond
    import dkc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pulse_valid,
    input  act_t              act,
    input  logic [WORD_W-1:0] acc_in,
    input  logic [WORD_W-1:0] stat_q,
    input  logic [WORD_W-1:0] stat_next,
    input  logic [FUNC_W-1:0] cmd_func,
    input  logic [SEL_W-1:0]  cmd_sel,
    input  logic              cmd_cyhi,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] acc_out,
    output logic              skip,
    output logic              go_valid,
    output logic [FUNC_W-1:0] go_func,
    output logic [SEL_W-1:0]  go_drive,
    output logic [CYL_W-1:0]  go_cyl,
    output logic              cancel_all
);
    logic [WORD_W-1:0] ret_word;
    logic              any_go;

    always_comb begin
        unique case (act.ret)
            RET_PASS: ret_word = acc_in;
            RET_STAT: ret_word = stat_next;
            default:  ret_word = '0;
        endcase
    end

    assign any_go = pulse_valid && (act.launch || act.launch_seek0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            acc_out    <= '0;
            skip       <= 1'b0;
            go_valid   <= 1'b0;
            go_func    <= '0;
            go_drive   <= '0;
            go_cyl     <= '0;
            cancel_all <= 1'b0;
        end else begin
            rsp_valid  <= pulse_valid;
            acc_out    <= pulse_valid ? ret_word : '0;
            skip       <= pulse_valid && act.test_skip && attention(stat_q);
            go_valid   <= any_go;
            cancel_all <= pulse_valid && act.clr_ctrl;
            if (any_go) begin
                go_drive <= cmd_sel;
                go_func  <= act.launch_seek0 ? FN_SEEK : cmd_func;
                go_cyl   <= act.launch_seek0 ? '0 : cyl_of(cmd_cyhi, acc_in);
            end else begin
                go_drive <= '0;
                go_func  <= '0;
                go_cyl   <= '0;
            end
        end
    end

    a_r13_response_latency: assert property (@(posedge clk) disable iff (rst)
        pulse_valid |=> rsp_valid);

    a_r2_skip_only_on_test: assert property (@(posedge clk) disable iff (rst)
        skip |-> ($past(pulse_valid) && $past(act.test_skip)));
endmodule

// File: rtl/dkc_regif.sv
module dkc_regif
    import dkc_pkg::*;
#(
    parameter int N_DRV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pulse_valid,
    input  logic [2:0]  pulse_code,
    input  logic [11:0] acc_in,
    input  logic [3:0]  drv_ready,
    input  logic [3:0]  drv_active,
    input  logic        ex_valid,
    input  logic [11:0] ex_stat_set,
    input  logic        ex_busy,
    output logic        rsp_valid,
    output logic [11:0] acc_out,
    output logic        skip,
    output logic        go_valid,
    output logic [2:0]  go_func,
    output logic [1:0]  go_drive,
    output logic [7:0]  go_cyl,
    output logic        cancel_all,
    output logic [11:0] stat_o,
    output logic [11:0] cmd_o,
    output logic [11:0] dskaddr_o,
    output logic [11:0] memaddr_o,
    output logic        busy_o,
    output logic        irq_o
);
    act_t              act;
    logic [WORD_W-1:0] stat_next;

    dkc_decode u_decode (
        .op       (pulse_code),
        .clr_code (acc_in[1:0]),
        .busy     (busy_o),
        .act      (act)
    );

    dkc_regfile #(.N_DRV(N_DRV)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .pulse_valid (pulse_valid),
        .act         (act),
        .acc_in      (acc_in),
        .drv_ready   (drv_ready),
        .drv_active  (drv_active),
        .ex_valid    (ex_valid),
        .ex_stat_set (ex_stat_set),
        .ex_busy     (ex_busy),
        .stat_q      (stat_o),
        .stat_next   (stat_next),
        .cmd_q       (cmd_o),
        .da_q        (dskaddr_o),
        .ma_q        (memaddr_o),
        .busy_q      (busy_o),
        .irq_q       (irq_o)
    );

    dkc_respond u_resp (
        .clk         (clk),
        .rst         (rst),
        .pulse_valid (pulse_valid),
        .act         (act),
        .acc_in      (acc_in),
        .stat_q      (stat_o),
        .stat_next   (stat_next),
        .cmd_func    (cmd_o[CM_FUNC_LO +: FUNC_W]),
        .cmd_sel     (cmd_o[CM_SEL_LO +: SEL_W]),
        .cmd_cyhi    (cmd_o[CM_CYHI]),
        .rsp_valid   (rsp_valid),
        .acc_out     (acc_out),
        .skip        (skip),
        .go_valid    (go_valid),
        .go_func     (go_func),
        .go_drive    (go_drive),
        .go_cyl      (go_cyl),
        .cancel_all  (cancel_all)
    );

    a_r12_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(pulse_valid && ex_valid));

    a_r5_launch_only_idle: assert property (@(posedge clk) disable iff (rst)
        go_valid |-> !$past(busy_o));

    a_r7_cancel_clears_ctrl: assert property (@(posedge clk) disable iff (rst)
        cancel_all |-> (cmd_o == '0 && dskaddr_o == '0 && memaddr_o == '0 && !busy_o));

    a_r11_idle_codes_keep_regs: assert property (@(posedge clk) disable iff (rst)
        (pulse_valid && (pulse_code == 3'd0 || pulse_code == 3'd7)) |=>
            ($stable(cmd_o) && $stable(dskaddr_o) && $stable(memaddr_o) && $stable(stat_o)));
endmodule

// File: tb/test_dkc_regif.sv
`timescale 1ns/1ps
module test_dkc_regif;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pv = 1'b0;
    logic [2:0]  pc = '0;
    logic [11:0] acc = '0;
    logic [3:0]  drdy = 4'hF;
    logic [3:0]  dact = 4'h0;
    logic        exv = 1'b0;
    logic [11:0] exs = '0;
    logic        exb = 1'b0;

    logic        rsp_valid, skip, go_valid, cancel_all, busy_o, irq_o;
    logic [11:0] acc_out, stat_o, cmd_o, dskaddr_o, memaddr_o;
    logic [2:0]  go_func;
    logic [1:0]  go_drive;
    logic [7:0]  go_cyl;

    always #2.5 clk = ~clk;

    dkc_regif i_dkc_regif (
        .clk(clk), .rst(rst), .pulse_valid(pv), .pulse_code(pc), .acc_in(acc),
        .drv_ready(drdy), .drv_active(dact), .ex_valid(exv), .ex_stat_set(exs),
        .ex_busy(exb), .rsp_valid(rsp_valid), .acc_out(acc_out), .skip(skip),
        .go_valid(go_valid), .go_func(go_func), .go_drive(go_drive), .go_cyl(go_cyl),
        .cancel_all(cancel_all), .stat_o(stat_o), .cmd_o(cmd_o), .dskaddr_o(dskaddr_o),
        .memaddr_o(memaddr_o), .busy_o(busy_o), .irq_o(irq_o)
    );

    int checks = 0;
    int failures = 0;
    bit started = 0;
    bit done_flag = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_stat, m_cmd, m_da, m_ma, m_busy, m_irq;
    int m_rsp, m_acc, m_skip, m_go, m_gf, m_gd, m_gc, m_cancel;

    always @(posedge clk) begin
        if (rst) begin
            m_stat = 0; m_cmd = 0; m_da = 0; m_ma = 0; m_busy = 0; m_irq = 0;
            m_rsp = 0; m_acc = 0; m_skip = 0; m_go = 0; m_gf = 0; m_gd = 0; m_gc = 0; m_cancel = 0;
            started = 1;
        end else begin
            int a, drv, again;
            a = int'(acc);
            m_rsp = 0; m_acc = 0; m_skip = 0; m_go = 0; m_gf = 0; m_gd = 0; m_gc = 0; m_cancel = 0;
            if (pv) begin
                m_rsp = 1;
                again = 1;
                drv = (m_cmd >> 1) & 3;
                case (int'(pc))
                    1: begin
                        m_skip = ((m_stat & 'o4177) != 0) ? 1 : 0;
                        m_acc = a;
                    end
                    2: begin
                        m_stat = 0;
                        case (a & 3)
                            0: if (m_busy != 0) m_stat = 'o100;
                            1: begin m_cmd = 0; m_da = 0; m_ma = 0; m_busy = 0; m_cancel = 1; end
                            2: if (m_busy != 0) m_stat = 'o100;
                               else begin m_go = 1; m_gf = 3; m_gc = 0; m_gd = drv; end
                            default: ;
                        endcase
                    end
                    3: if (m_busy != 0) m_stat = m_stat | 'o100;
                       else begin
                           m_da = a; m_go = 1; m_gf = (m_cmd >> 9) & 7; m_gd = drv;
                           m_gc = ((m_cmd & 1) << 7) | (a >> 5);
                       end
                    4: if (m_busy != 0) m_stat = m_stat | 'o100; else m_ma = a;
                    5: begin
                        m_stat = m_stat & ~'o2200;
                        if (dact[drv]) m_stat = m_stat | 'o2000;
                        if (!drdy[drv]) m_stat = m_stat | 'o200;
                        m_acc = m_stat;
                        again = 0;
                    end
                    6: if (m_busy != 0) m_stat = m_stat | 'o100;
                       else begin m_cmd = a; m_stat = 0; end
                    default: ;
                endcase
                if (again != 0)
                    m_irq = (((m_cmd & 'o400) != 0) && ((m_stat & 'o4177) != 0)) ? 1 : 0;
            end else if (exv) begin
                m_stat = m_stat | int'(exs);
                m_busy = exb ? 1 : 0;
                m_irq = (((m_cmd & 'o400) != 0) && ((m_stat & 'o4177) != 0)) ? 1 : 0;
            end
        end
    end

    // cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (started && !done_flag) begin
            logic [91:0] got, exp;
            got = {rsp_valid, acc_out, skip, go_valid, go_func, go_drive, go_cyl, cancel_all,
                   stat_o, cmd_o, dskaddr_o, memaddr_o, busy_o, irq_o, 24'd0};
            exp = {m_rsp[0], m_acc[11:0], m_skip[0], m_go[0], m_gf[2:0], m_gd[1:0], m_gc[7:0],
                   m_cancel[0], m_stat[11:0], m_cmd[11:0], m_da[11:0], m_ma[11:0],
                   m_busy[0], m_irq[0], 24'd0};
            checks++;
            if (got !== exp) begin
                failures++;
                $display("FAIL %s actual=%h expected=%h (t=%0t)", cur_req, got, exp, $time);
            end
        end
    end

    task automatic check_val(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%o expected=%o", req, actual, expected);
        end
    endtask

    task automatic pulse(input int code, input int value);
        @(negedge clk);
        pv = 1'b1; pc = code[2:0]; acc = value[11:0];
        @(negedge clk);
        pv = 1'b0; acc = '0;
    endtask

    task automatic event_ex(input int bits, input bit b);
        @(negedge clk);
        exv = 1'b1; exs = bits[11:0]; exb = b;
        @(negedge clk);
        exv = 1'b0; exs = '0; exb = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cur_req = "R1";
        check_val("R1", int'({stat_o, cmd_o}), 0);
        check_val("R1", int'({busy_o, irq_o, go_valid, rsp_valid}), 0);

        cur_req = "R2";
        pulse(1, 'o1234);
        check_val("R2", int'(skip), 0);
        check_val("R13", int'(acc_out), 'o1234);

        cur_req = "R3";
        pulse(6, 'o0403);          // IE, drive 1, high cylinder bit
        check_val("R3", int'(cmd_o), 'o0403);

        cur_req = "R4";
        pulse(4, 'o7700);
        check_val("R4", int'(memaddr_o), 'o7700);

        cur_req = "R5";
        @(negedge clk); pv = 1'b1; pc = 3'd3; acc = 12'o5360;
        @(negedge clk); pv = 1'b0;
        check_val("R5", int'(go_valid), 1);
        check_val("R5", int'(go_cyl), 'o200 | ('o5360 >> 5));
        check_val("R5", int'(go_drive), 1);
        check_val("R13", int'(acc_out), 0);
        @(negedge clk);
        check_val("R13", int'(go_valid), 0);

        cur_req = "R12";
        event_ex(0, 1'b1);
        check_val("R12", int'(busy_o), 1);

        cur_req = "R3";
        pulse(6, 'o7777);
        check_val("R3", int'(cmd_o), 'o0403);
        check_val("R10", int'(irq_o), 1);
        cur_req = "R4";
        pulse(4, 'o0055);
        check_val("R4", int'(memaddr_o), 'o7700);
        cur_req = "R5";
        pulse(3, 'o0040);
        check_val("R5", int'(dskaddr_o), 'o5360);
        cur_req = "R2";
        pulse(1, 0);
        check_val("R2", int'(skip), 1);

        cur_req = "R6";
        pulse(2, 3);
        check_val("R6", int'(stat_o), 0);
        pulse(2, 0);
        check_val("R6", int'(stat_o), 'o100);
        cur_req = "R8";
        pulse(2, 2);
        check_val("R8", int'(stat_o), 'o100);

        cur_req = "R9";
        drdy = 4'b1101; dact = 4'b0010;
        @(negedge clk);
        pulse(5, 0);
        check_val("R9", int'(acc_out), 'o2300);
        check_val("R10", int'(irq_o), 1);
        drdy = 4'hF; dact = 4'h0;

        cur_req = "R10";
        event_ex('o4000, 1'b0);
        check_val("R12", int'(stat_o), 'o6300);

        cur_req = "R8";
        pulse(2, 2);
        check_val("R8", int'(go_func), 3);

        cur_req = "R11";
        pulse(0, 'o7777);
        pulse(7, 'o1111);
        check_val("R11", int'(cmd_o), 'o0403);

        cur_req = "R7";
        pulse(2, 1);
        check_val("R7", int'(cmd_o), 0);

        cur_req = "R10";
        event_ex('o0001, 1'b0);
        check_val("R10", int'(irq_o), 0);

        cur_req = "R13";
        for (int i = 0; i < 600; i++) begin
            int r;
            r = int'($urandom_range(0, 9));
            drdy = 4'($urandom); dact = 4'($urandom);
            if (r < 2) event_ex(int'($urandom) & 'o7777, 1'($urandom));
            else if (r < 4) pulse(int'($urandom_range(0, 7)), int'($urandom) & 'o7777);
            else if (r == 4) pulse(2, int'($urandom_range(0, 3)));
            else pulse(int'($urandom_range(3, 6)), int'($urandom) & 'o7777);
        end

        repeat (2) @(negedge clk);
        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule